// File: doc/BRIEF.md
# Masked Compare-and-Swap Read Unit

This block sits between a local requester and a remote bus and turns one chosen read location into an atomic compare-and-swap site. Software programs a control word, a target word address, an enable mask, a compare pattern and a swap pattern through a small write port. While the unit is armed, an ordinary local read that falls on the target word, in the selected address space, becomes a locked sequence on the remote bus. The word is read. Under the mask, its enabled bits are compared with the compare pattern. When all enabled bits agree, a write follows before the lock is dropped. The write carries the swap bits in the enabled positions and the bits just read everywhere else.

All other reads, including reads when the unit is disabled or set to the address-only mode, go out as single unlocked reads. The requester always gets the word exactly as it was read, whether or not the swap happened. A remote bus error in either phase ends the sequence at once, drops the lock and raises an error flag on the response.

Top module: `rmw_unit`

## Requirements
- R1: After reset, req_ready is 1, and rb_req, rb_we, rb_lock and resp_valid are all 0. The mode is disabled.
- R2: Config index 0 holds the control word: bits [1:0] are the mode (0 disabled, 1 compare-and-swap on read, 2 address-only, 3 treated as disabled) and bit 2 is the space select (1 I/O, 0 memory). Index 1 is the target address, index 2 the enable mask, index 3 the compare pattern and index 4 the swap pattern. Writes to indices 5 to 7 change nothing.
- R3: A read is a hit only if the mode is 1, req_io equals the space select, and req_addr equals the target address with the low two address bits ignored. The remote address of every locked cycle has its low two bits forced to zero.
- R4: A read that is not a hit produces exactly one unlocked remote read at the unchanged request address, and no write.
- R5: On a hit, the compare succeeds when ((read ^ compare) & mask) == 0. On success, one write of (read & ~mask) | (swap & mask) goes to the same word address.
- R6: On a hit whose compare fails, no write is issued, and rb_lock falls in the cycle after the read acknowledge.
- R7: For a hit, rb_lock is high in every cycle in which rb_req is high, from the read through the end of the write, and falls together with rb_req after the final acknowledge. It is never high for a non-hit.
- R8: resp_valid pulses for one cycle, in the cycle after the final remote acknowledge. resp_data is then the word returned by the remote read, with resp_err 0 on success.
- R9: If rb_err is returned in the read or the write phase, the sequence ends with no further remote cycle, rb_lock falls, and the response carries resp_err 1. After a read error no write is issued.
- R10: While rb_req is high and neither rb_ack nor rb_err has come, rb_addr, rb_we and rb_wdata stay stable. A write is only issued with rb_lock high.
- R11: Only one read is outstanding at a time. req_ready is low from the cycle after acceptance until resp_valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_idx | input | 3 | Configuration register index |
| cfg_wdata | input | DW | Configuration write data |
| req_valid | input | 1 | Local read request |
| req_ready | output | 1 | Unit can accept a request |
| req_addr | input | AW | Local read address |
| req_io | input | 1 | Request targets I/O space (1) or memory (0) |
| resp_valid | output | 1 | One-cycle response strobe |
| resp_data | output | DW | Word read from the remote bus |
| resp_err | output | 1 | Remote bus error during the sequence |
| rb_req | output | 1 | Remote cycle request, held until acknowledge or error |
| rb_we | output | 1 | Remote cycle is a write |
| rb_lock | output | 1 | Remote bus lock |
| rb_addr | output | AW | Remote address |
| rb_wdata | output | DW | Remote write data |
| rb_rdata | input | DW | Remote read data, valid with rb_ack |
| rb_ack | input | 1 | Remote cycle complete |
| rb_err | input | 1 | Remote cycle ended in error |

## Verification
A wrong sequencer state would show up as a remote request with the lock low during a hit, as a lock left high after the response, or as a write appearing after a failed compare. Each of these is visible on the remote port within the transaction that caused it. A wrong merge or compare shows up in the written-back word as soon as that write is acknowledged, and a wrong captured read word shows up in resp_data in the following response. An exhaustive sweep of every 8-bit read value against a fixed mask and compare pattern makes sure that every compare outcome and every merged bit is seen at least once.

// File: rtl/rmw_pkg.sv
package rmw_pkg;
  localparam int IDX_W = 3;

  localparam logic [IDX_W-1:0] IDX_CTL  = 3'd0;
  localparam logic [IDX_W-1:0] IDX_ADDR = 3'd1;
  localparam logic [IDX_W-1:0] IDX_MASK = 3'd2;
  localparam logic [IDX_W-1:0] IDX_CMP  = 3'd3;
  localparam logic [IDX_W-1:0] IDX_SWP  = 3'd4;

  typedef enum logic [1:0] {
    MODE_OFF       = 2'd0,
    MODE_RMW       = 2'd1,
    MODE_ADDR_ONLY = 2'd2,
    MODE_RSVD      = 2'd3
  } rmw_mode_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RD   = 2'd1,
    ST_WR   = 2'd2
  } rmw_state_e;
endpackage

// File: rtl/rmw_regs.sv
module rmw_regs
  import rmw_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_we,
  input  logic [IDX_W-1:0] cfg_idx,
  input  logic [DW-1:0]    cfg_wdata,
  output rmw_mode_e        mode,
  output logic             space_io,
  output logic [AW-1:0]    tgt_addr,
  output logic [DW-1:0]    mask,
  output logic [DW-1:0]    cmp,
  output logic [DW-1:0]    swp
);
  localparam int ALIGN = 2;

  always_ff @(posedge clk) begin
    if (rst) begin
      mode     <= MODE_OFF;
      space_io <= 1'b0;
      tgt_addr <= '0;
      mask     <= '0;
      cmp      <= '0;
      swp      <= '0;
    end else if (cfg_we) begin
      case (cfg_idx)
        IDX_CTL: begin
          mode     <= rmw_mode_e'(cfg_wdata[1:0]);
          space_io <= cfg_wdata[2];
        end
        IDX_ADDR: tgt_addr <= {cfg_wdata[AW-1:ALIGN], {ALIGN{1'b0}}};
        IDX_MASK: mask     <= cfg_wdata;
        IDX_CMP:  cmp      <= cfg_wdata;
        IDX_SWP:  swp      <= cfg_wdata;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/rmw_match.sv
module rmw_match
  import rmw_pkg::*;
#(
  parameter int AW = 32
) (
  input  rmw_mode_e     mode,
  input  logic          space_io,
  input  logic [AW-1:0] tgt_addr,
  input  logic [AW-1:0] req_addr,
  input  logic          req_io,
  output logic          hit
);
  localparam int ALIGN = 2;

  // Address-only and reserved modes decode as "not armed": those reads pass through.
  logic armed;
  assign armed = (mode == MODE_RMW);
  assign hit   = armed && (req_io == space_io) &&
                 (req_addr[AW-1:ALIGN] == tgt_addr[AW-1:ALIGN]);
endmodule

// File: rtl/rmw_cas.sv
module rmw_cas #(
  parameter int DW = 32
) (
  input  logic [DW-1:0] rd,
  input  logic [DW-1:0] mask,
  input  logic [DW-1:0] cmp,
  input  logic [DW-1:0] swp,
  output logic          match,
  output logic [DW-1:0] merged
);
  logic [DW-1:0] diff;

  for (genvar i = 0; i < DW; i++) begin : g_bit
    assign diff[i]   = mask[i] & (rd[i] ^ cmp[i]);
    assign merged[i] = mask[i] ? swp[i] : rd[i];
  end

  assign match = ~|diff;
endmodule

// File: rtl/rmw_seq.sv
module rmw_seq
  import rmw_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [AW-1:0] req_addr,
  input  logic          req_hit,
  output logic          resp_valid,
  output logic [DW-1:0] resp_data,
  output logic          resp_err,
  input  logic          cas_match,
  input  logic [DW-1:0] cas_word,
  output logic          rb_req,
  output logic          rb_we,
  output logic          rb_lock,
  output logic [AW-1:0] rb_addr,
  output logic [DW-1:0] rb_wdata,
  input  logic [DW-1:0] rb_rdata,
  input  logic          rb_ack,
  input  logic          rb_err
);
  localparam int ALIGN = 2;

  rmw_state_e st;
  logic       hit_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= ST_IDLE;
      hit_q      <= 1'b0;
      req_ready  <= 1'b1;
      resp_valid <= 1'b0;
      resp_data  <= '0;
      resp_err   <= 1'b0;
      rb_req     <= 1'b0;
      rb_we      <= 1'b0;
      rb_lock    <= 1'b0;
      rb_addr    <= '0;
      rb_wdata   <= '0;
    end else begin
      resp_valid <= 1'b0;
      case (st)
        ST_IDLE: begin
          if (req_valid) begin
            req_ready <= 1'b0;
            rb_req    <= 1'b1;
            rb_we     <= 1'b0;
            rb_lock   <= req_hit;
            hit_q     <= req_hit;
            rb_addr   <= req_hit ? {req_addr[AW-1:ALIGN], {ALIGN{1'b0}}} : req_addr;
            st        <= ST_RD;
          end
        end
        ST_RD: begin
          if (rb_err) begin
            rb_req     <= 1'b0;
            rb_lock    <= 1'b0;
            resp_valid <= 1'b1;
            resp_data  <= '0;
            resp_err   <= 1'b1;
            req_ready  <= 1'b1;
            st         <= ST_IDLE;
          end else if (rb_ack) begin
            resp_data <= rb_rdata;
            resp_err  <= 1'b0;
            if (hit_q && cas_match) begin
              rb_we    <= 1'b1;
              rb_wdata <= cas_word;
              st       <= ST_WR;
            end else begin
              rb_req     <= 1'b0;
              rb_lock    <= 1'b0;
              resp_valid <= 1'b1;
              req_ready  <= 1'b1;
              st         <= ST_IDLE;
            end
          end
        end
        ST_WR: begin
          if (rb_ack || rb_err) begin
            rb_req     <= 1'b0;
            rb_we      <= 1'b0;
            rb_lock    <= 1'b0;
            resp_valid <= 1'b1;
            resp_err   <= rb_err;
            req_ready  <= 1'b1;
            st         <= ST_IDLE;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assert_wr_locked_R10: assert property (@(posedge clk) disable iff (rst)
    rb_we |-> (rb_lock && rb_req));

  assert_req_hold_R10: assert property (@(posedge clk) disable iff (rst)
    (rb_req && !rb_ack && !rb_err) |=>
      (rb_req && $stable(rb_addr) && $stable(rb_we) && $stable(rb_wdata)));

  assert_lock_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (rb_lock && !rb_ack && !rb_err) |=> rb_lock);

  assert_lock_start_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(rb_lock) |-> (rb_req && !rb_we));

  assert_resp_released_R8: assert property (@(posedge clk) disable iff (rst)
    resp_valid |-> (!rb_req && !rb_lock && req_ready));

  assert_err_release_R9: assert property (@(posedge clk) disable iff (rst)
    (rb_req && rb_err) |=> (!rb_req && !rb_lock && resp_valid && resp_err));

  assert_one_outstanding_R11: assert property (@(posedge clk) disable iff (rst)
    (req_ready && req_valid) |=> (!req_ready && rb_req));
endmodule

// File: rtl/rmw_unit.sv
module rmw_unit
  import rmw_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_we,
  input  logic [IDX_W-1:0] cfg_idx,
  input  logic [DW-1:0]    cfg_wdata,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [AW-1:0]    req_addr,
  input  logic             req_io,
  output logic             resp_valid,
  output logic [DW-1:0]    resp_data,
  output logic             resp_err,
  output logic             rb_req,
  output logic             rb_we,
  output logic             rb_lock,
  output logic [AW-1:0]    rb_addr,
  output logic [DW-1:0]    rb_wdata,
  input  logic [DW-1:0]    rb_rdata,
  input  logic             rb_ack,
  input  logic             rb_err
);
  rmw_mode_e     mode;
  logic          space_io;
  logic [AW-1:0] tgt_addr;
  logic [DW-1:0] mask, cmp, swp;
  logic          hit;
  logic          cas_match;
  logic [DW-1:0] cas_word;

  rmw_regs #(.AW(AW), .DW(DW)) u_regs (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_wdata(cfg_wdata),
    .mode(mode), .space_io(space_io), .tgt_addr(tgt_addr),
    .mask(mask), .cmp(cmp), .swp(swp)
  );

  rmw_match #(.AW(AW)) u_match (
    .mode(mode), .space_io(space_io), .tgt_addr(tgt_addr),
    .req_addr(req_addr), .req_io(req_io), .hit(hit)
  );

  rmw_cas #(.DW(DW)) u_cas (
    .rd(rb_rdata), .mask(mask), .cmp(cmp), .swp(swp),
    .match(cas_match), .merged(cas_word)
  );

  rmw_seq #(.AW(AW), .DW(DW)) u_seq (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr), .req_hit(hit),
    .resp_valid(resp_valid), .resp_data(resp_data), .resp_err(resp_err),
    .cas_match(cas_match), .cas_word(cas_word),
    .rb_req(rb_req), .rb_we(rb_we), .rb_lock(rb_lock), .rb_addr(rb_addr),
    .rb_wdata(rb_wdata), .rb_rdata(rb_rdata), .rb_ack(rb_ack), .rb_err(rb_err)
  );
endmodule

// File: tb/rmw_unit_tb.sv
`timescale 1ns/1ps
module rmw_unit_tb;
  localparam int AW = 8;
  localparam int DW = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  logic          cfg_we = 1'b0;
  logic [2:0]    cfg_idx = '0;
  logic [DW-1:0] cfg_wdata = '0;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic [AW-1:0] req_addr = '0;
  logic          req_io = 1'b0;
  logic          resp_valid;
  logic [DW-1:0] resp_data;
  logic          resp_err;
  logic          rb_req, rb_we, rb_lock;
  logic [AW-1:0] rb_addr;
  logic [DW-1:0] rb_wdata;
  logic [DW-1:0] rb_rdata;
  logic          rb_ack, rb_err;

  rmw_unit #(.AW(AW), .DW(DW)) u_dut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_wdata(cfg_wdata),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr), .req_io(req_io),
    .resp_valid(resp_valid), .resp_data(resp_data), .resp_err(resp_err),
    .rb_req(rb_req), .rb_we(rb_we), .rb_lock(rb_lock), .rb_addr(rb_addr),
    .rb_wdata(rb_wdata), .rb_rdata(rb_rdata), .rb_ack(rb_ack), .rb_err(rb_err)
  );

  // Remote bus model: owns its memory; pokes come from the stimulus through poke_*.
  logic [DW-1:0] mem [64];
  int  lat = 1;
  int  cnt = 0;
  bit  err_rd = 0, err_wr = 0;
  bit  poke_en = 0;
  logic [5:0]    poke_idx = '0;
  logic [DW-1:0] poke_val = '0;
  int  n_wr = 0, n_rd = 0, req_cyc = 0, lk_cyc = 0, bad_al = 0;
  logic [AW-1:0] last_rd_addr = '0;

  always @(posedge clk) begin
    if (rst) begin
      rb_ack <= 1'b0; rb_err <= 1'b0; rb_rdata <= '0; cnt <= 0;
    end else begin
      rb_ack <= 1'b0; rb_err <= 1'b0;
      if (poke_en) mem[poke_idx] <= poke_val;
      if (rb_req) begin
        req_cyc <= req_cyc + 1;
        if (rb_lock) lk_cyc <= lk_cyc + 1;
        if (rb_lock && rb_addr[1:0] != 2'b00) bad_al <= bad_al + 1;
      end
      if (rb_req && !rb_ack && !rb_err) begin
        if (cnt >= lat) begin
          cnt <= 0;
          if ((rb_we && err_wr) || (!rb_we && err_rd)) rb_err <= 1'b1;
          else begin
            rb_ack <= 1'b1;
            if (rb_we) begin mem[rb_addr[7:2]] <= rb_wdata; n_wr <= n_wr + 1; end
            else begin rb_rdata <= mem[rb_addr[7:2]]; n_rd <= n_rd + 1; last_rd_addr <= rb_addr; end
          end
        end else cnt <= cnt + 1;
      end
    end
  end

  int total = 0, bad = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cfg(input logic [2:0] idx, input logic [DW-1:0] val);
    @(negedge clk); cfg_we = 1'b1; cfg_idx = idx; cfg_wdata = val;
    @(negedge clk); cfg_we = 1'b0;
  endtask

  task automatic poke(input logic [5:0] idx, input logic [DW-1:0] val);
    @(negedge clk); poke_en = 1; poke_idx = idx; poke_val = val;
    @(negedge clk); poke_en = 0;
  endtask

  task automatic rd(input logic [AW-1:0] a, input logic io,
                    output logic [DW-1:0] d, output logic e, output bit busy_ok);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_io = io;
    @(negedge clk);
    req_valid = 1'b0;
    busy_ok = !req_ready;
    for (int k = 0; k < 200 && !resp_valid; k++) @(negedge clk);
    d = resp_data; e = resp_err;
    if (!resp_valid) begin
      total++; bad++;
      $display("FAIL R8 actual=no-response expected=resp_valid");
    end
    @(negedge clk);
    chk(resp_valid == 1'b0, "R8 pulse-width", resp_valid, 0);
  endtask

  // One locked-read attempt with full expectation checks.
  task automatic hit_case(input logic [DW-1:0] init, input logic [DW-1:0] m,
                          input logic [DW-1:0] c, input logic [DW-1:0] s,
                          input logic [AW-1:0] a, input logic io);
    logic [DW-1:0] d, expw; logic e; bit b; bit match;
    int w0, r0, q0, l0;
    poke(a[7:2], init);
    w0 = n_wr; q0 = req_cyc; l0 = lk_cyc; r0 = n_rd;
    rd(a, io, d, e, b);
    match = ((init ^ c) & m) == '0;
    expw  = match ? ((init & ~m) | (s & m)) : init;
    chk(d == init && !e, "R8 read data", d, init);
    chk(mem[a[7:2]] == expw, "R5 written word", mem[a[7:2]], expw);
    chk((n_wr - w0) == (match ? 1 : 0), match ? "R5 write count" : "R6 no write", n_wr - w0, match);
    chk((req_cyc - q0) == (lk_cyc - l0) && (lk_cyc - l0) > 0, "R7 lock every cycle", lk_cyc - l0, req_cyc - q0);
    chk(n_rd - r0 == 1 && bad_al == 0, "R3 aligned single read", bad_al, 0);
    chk(!rb_lock, "R6 lock released", rb_lock, 0);
  endtask

  task automatic miss_case(input logic [AW-1:0] a, input logic io, input string tag);
    logic [DW-1:0] d; logic e; bit b; int w0, l0, r0;
    poke(a[7:2], 8'h5A ^ a);
    w0 = n_wr; l0 = lk_cyc; r0 = n_rd;
    rd(a, io, d, e, b);
    chk(d == (8'h5A ^ a) && !e, {tag, " data"}, d, 8'h5A ^ a);
    chk(n_wr == w0 && lk_cyc == l0 && n_rd == r0 + 1, {tag, " unlocked single read"}, lk_cyc - l0, 0);
    chk(last_rd_addr == a, "R4 address unchanged", last_rd_addr, a);
  endtask

  initial begin
    logic [DW-1:0] d; logic e; bit b; int w0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(req_ready && !rb_req && !rb_we && !rb_lock && !resp_valid, "R1 reset state",
        {req_ready, rb_req, rb_we, rb_lock, resp_valid}, 5'b10000);

    // R1 default mode disabled: target-looking read passes through
    miss_case(8'h00, 1'b0, "R1 default off");

    // R2 programming; R3 low address bits of target dropped
    cfg(3'd0, 8'h01);
    cfg(3'd1, 8'h27);
    cfg(3'd2, 8'h3C);
    cfg(3'd3, 8'h14);
    cfg(3'd4, 8'hA5);

    // R5/R6 exhaustive sweep of read values, low request bits differ from target
    for (int v = 0; v < 256; v++) hit_case(v[7:0], 8'h3C, 8'h14, 8'hA5, 8'h26, 1'b0);

    // R11 busy flag during a transaction
    lat = 3;
    poke(6'd9, 8'h00);
    rd(8'h24, 1'b0, d, e, b);
    chk(b, "R11 req_ready low while busy", 0, 1);
    hit_case(8'h14, 8'h3C, 8'h14, 8'hA5, 8'h25, 1'b0);
    hit_case(8'h00, 8'h3C, 8'h14, 8'hA5, 8'h27, 1'b0);
    lat = 1;

    // R2 writes to unused indices change nothing
    cfg(3'd5, 8'h00); cfg(3'd6, 8'hFF); cfg(3'd7, 8'h00);
    hit_case(8'hD7, 8'h3C, 8'h14, 8'hA5, 8'h24, 1'b0);
    hit_case(8'hC3, 8'h3C, 8'h14, 8'hA5, 8'h24, 1'b0);

    // R3/R4 misses: wrong space, wrong word
    miss_case(8'h24, 1'b1, "R3 wrong space");
    miss_case(8'h28, 1'b0, "R3 wrong word");
    miss_case(8'h20, 1'b0, "R4 neighbour word");

    // R2 mode 2 and 3 pass through
    cfg(3'd0, 8'h02);
    miss_case(8'h24, 1'b0, "R2 address-only mode");
    cfg(3'd0, 8'h03);
    miss_case(8'h24, 1'b0, "R2 reserved mode");

    // R2 space bit: I/O hits only with io=1
    cfg(3'd0, 8'h05);
    hit_case(8'h55, 8'h3C, 8'h14, 8'hA5, 8'h24, 1'b1);
    miss_case(8'h24, 1'b0, "R3 memory read in io mode");

    // R5 zero mask always matches and writes back read word
    cfg(3'd0, 8'h01);
    cfg(3'd2, 8'h00);
    for (int v = 0; v < 16; v++) hit_case(v[7:0] * 8'd17, 8'h00, 8'h14, 8'hA5, 8'h24, 1'b0);
    // R5 full mask, full-word compare
    cfg(3'd2, 8'hFF); cfg(3'd3, 8'h81); cfg(3'd4, 8'h7E);
    hit_case(8'h81, 8'hFF, 8'h81, 8'h7E, 8'h24, 1'b0);
    hit_case(8'h80, 8'hFF, 8'h81, 8'h7E, 8'h24, 1'b0);

    // R9 read error
    poke(6'd9, 8'h81);
    err_rd = 1; w0 = n_wr;
    rd(8'h24, 1'b0, d, e, b);
    err_rd = 0;
    chk(e == 1'b1, "R9 read error flag", e, 1);
    chk(n_wr == w0 && mem[9] == 8'h81 && !rb_lock, "R9 no write after read error", n_wr - w0, 0);

    // R9 write error: original data returned, memory unchanged
    err_wr = 1; w0 = n_wr;
    rd(8'h24, 1'b0, d, e, b);
    err_wr = 0;
    chk(e == 1'b1 && d == 8'h81, "R9 write error flag", {e, d}, 9'h181);
    chk(mem[9] == 8'h81 && !rb_lock && !rb_req, "R9 write error released", mem[9], 8'h81);

    // R1 reset clears configuration again
    @(negedge clk); rst = 1'b1; @(negedge clk); rst = 1'b0;
    miss_case(8'h24, 1'b0, "R1 mode off after reset");

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule